// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a blocking data cache placed between a processor's load/store port and a slower block-wide memory port. It stores 1024 lines of four 32-bit words, 16 KB in all, and places each line at exactly one location chosen by the index bits of the byte address. Writes stay in the cache and mark the line dirty. A dirty line goes back to memory only when another line evicts it. A write that misses first fetches the whole line and then merges the word into it.

The processor strobes `cpu_req` for one cycle in Idle with the address, direction and write word. The cache raises `cpu_ready` for one cycle when the access is done, and `cpu_rdata` is valid in that cycle. A state machine sequences the work through four states. Idle accepts a request and latches it. CompareTag checks for a hit and either finishes the access or picks the miss path. WriteBack sends the dirty victim line to memory. Allocate reads the new line and always returns to CompareTag, so the access is then retried as a hit. The named transitions are: Idle→CompareTag on a request; CompareTag→Idle on a hit; CompareTag→WriteBack on a miss with a dirty victim; CompareTag→Allocate on a miss with a clean or empty victim; WriteBack→Allocate when memory acknowledges; and Allocate→CompareTag when memory acknowledges.

Each memory transaction moves one 128-bit line in a single valid/ready handshake, and memory may take any number of cycles to answer.

Top module: `dm_wb_cache`

## Requirements
- R1: After reset, `cpu_ready` and `mem_valid` are 0 and every line is invalid, so the first access to any address is a miss that reads memory.
- R2: The byte address is split as tag = bits [31:14], index = bits [13:4] and word select = bits [3:2]. Bits [1:0] are ignored. Memory addresses are line addresses {tag, index, 4'b0000}.
- R3: A read hit raises `cpu_ready` at the first sample after the request edge, with the addressed word on `cpu_rdata` and no memory transaction.
- R4: A write hit changes only the addressed word, sets the line's dirty bit and makes no memory transaction.
- R5: A miss whose victim is clean or invalid makes exactly one memory read (`mem_write` = 0) of the requested line and then completes as a hit. A freshly filled line is valid and clean.
- R6: A miss whose victim is valid and dirty first writes the whole victim line (`mem_write` = 1) to the victim's own line address and only then reads the new line.
- R7: A write miss allocates. The line is fetched, the written word is merged, and the other three words keep the memory values.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` hold their values.
- R9: `cpu_ready` is never high while a memory transaction is outstanding. The processor is stalled until all memory traffic of its access has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | One-cycle request strobe, sampled in Idle |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store word |
| cpu_rdata | output | 32 | Load word, valid with cpu_ready |
| cpu_ready | output | 1 | Access complete (one cycle) |
| mem_valid | output | 1 | Memory transaction request |
| mem_write | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_addr | output | 32 | Line address, low 4 bits zero |
| mem_wdata | output | 128 | Victim line data |
| mem_rdata | input | 128 | Fetched line data, valid with mem_ready |
| mem_ready | input | 1 | Memory acknowledge |

## Verification
The two functions that meet in one access are the eviction of a dirty victim and the write-allocate merge. A store that misses on a dirty line must first send the old line out, then fetch the new one, then write the word in the retried CompareTag cycle. This case is provoked by directed stores to one index under alternating tags, and by a long random run over 8 tags and 16 indices with random memory latency. The outcome is judged in three ways: the written-back line must match the bench's model of what the processor wrote, the write must come before the read, and a later read of the merged line must return the new word in its slot and memory's values in the other slots.

// File: rtl/cache_pkg.sv
`timescale 1ns/1ps
package cache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMP   = 2'd1,
        ST_WB    = 2'd2,
        ST_ALLOC = 2'd3
    } cstate_t;
endpackage

// File: rtl/cache_tags.sv
`timescale 1ns/1ps
module cache_tags #(
    parameter int LINES = 1024,
    parameter int TAG_W = 18,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             dirty_set,
    output logic [TAG_W-1:0] tag_o,
    output logic             valid_o,
    output logic             dirty_o
);
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (dirty_set) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[idx] <= fill_tag;
    end

    assign tag_o   = tag_q[idx];
    assign valid_o = valid_q[idx];
    assign dirty_o = dirty_q[idx];

    AST_DIRTY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_set |=> dirty_o); // R4
    AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (valid_o && !dirty_o)); // R5
endmodule

// File: rtl/cache_data.sv
`timescale 1ns/1ps
module cache_data #(
    parameter int LINES  = 1024,
    parameter int WORDS  = 4,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(LINES),
    localparam int SEL_W = $clog2(WORDS),
    localparam int BLK_W = WORDS * WORD_W
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic              fill_en,
    input  logic [BLK_W-1:0]  fill_blk,
    input  logic              word_en,
    input  logic [SEL_W-1:0]  word_sel,
    input  logic [WORD_W-1:0] word_in,
    output logic [BLK_W-1:0]  blk_o
);
    logic [BLK_W-1:0] line_q [LINES];
    logic [BLK_W-1:0] merged;

    always_comb begin
        merged = line_q[idx];
        for (int w = 0; w < WORDS; w++) begin
            if (word_sel == w[SEL_W-1:0]) merged[w*WORD_W +: WORD_W] = word_in;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en)      line_q[idx] <= fill_blk;
        else if (word_en) line_q[idx] <= merged;
    end

    assign blk_o = line_q[idx];
endmodule

// File: rtl/cache_fsm.sv
`timescale 1ns/1ps
module cache_fsm
    import cache_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cpu_req,
    input  logic    req_write,
    input  logic    hit,
    input  logic    victim_dirty,
    input  logic    mem_ready,
    output cstate_t state,
    output logic    latch_req,
    output logic    cpu_ready,
    output logic    word_wr,
    output logic    mem_valid,
    output logic    mem_write,
    output logic    fill_en
);
    cstate_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (cpu_req) nxt = ST_CMP;
            ST_CMP:   nxt = hit ? ST_IDLE : (victim_dirty ? ST_WB : ST_ALLOC);
            ST_WB:    if (mem_ready) nxt = ST_ALLOC;
            ST_ALLOC: if (mem_ready) nxt = ST_CMP;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        latch_req = 1'b0;
        cpu_ready = 1'b0;
        word_wr   = 1'b0;
        mem_valid = 1'b0;
        mem_write = 1'b0;
        fill_en   = 1'b0;
        unique case (state)
            ST_IDLE:  latch_req = cpu_req;
            ST_CMP: begin
                cpu_ready = hit;
                word_wr   = hit && req_write;
            end
            ST_WB: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
            end
            ST_ALLOC: begin
                mem_valid = 1'b1;
                fill_en   = mem_ready;
            end
            default: ;
        endcase
    end

    AST_DIRTY_GOES_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMP && !hit && victim_dirty) |=> state == ST_WB); // R6
    AST_WB_THEN_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WB && mem_ready) |=> state == ST_ALLOC); // R6
    AST_ALLOC_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ALLOC && mem_ready) |=> state == ST_CMP); // R5
endmodule

// File: rtl/dm_wb_cache.sv
`timescale 1ns/1ps
module dm_wb_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    parameter int LINES  = 1024,
    localparam int BLK_W = WORDS * WORD_W,
    localparam int OFF_W = $clog2(BLK_W / 8),
    localparam int BYTE_W = $clog2(WORD_W / 8),
    localparam int SEL_W = $clog2(WORDS),
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BLK_W-1:0]  mem_wdata,
    input  logic [BLK_W-1:0]  mem_rdata,
    input  logic              mem_ready
);
    cstate_t           state;
    logic              latch_req, word_wr, fill_en;
    logic [ADDR_W-1:BYTE_W] req_addr;
    logic              req_write;
    logic [WORD_W-1:0] req_wdata;
    logic [TAG_W-1:0]  req_tag, st_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [SEL_W-1:0]  req_sel;
    logic              st_valid, st_dirty, hit;
    logic [BLK_W-1:0]  blk;
    logic              unused_byte_bits;

    assign unused_byte_bits = &{1'b0, cpu_addr[BYTE_W-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_addr  <= '0;
            req_write <= 1'b0;
            req_wdata <= '0;
        end else if (latch_req) begin
            req_addr  <= cpu_addr[ADDR_W-1:BYTE_W];
            req_write <= cpu_write;
            req_wdata <= cpu_wdata;
        end
    end

    assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
    assign req_idx = req_addr[OFF_W +: IDX_W];
    assign req_sel = req_addr[BYTE_W +: SEL_W];
    assign hit     = st_valid && (st_tag == req_tag);

    cache_tags #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(req_idx),
        .fill_en(fill_en), .fill_tag(req_tag), .dirty_set(word_wr),
        .tag_o(st_tag), .valid_o(st_valid), .dirty_o(st_dirty)
    );

    cache_data #(.LINES(LINES), .WORDS(WORDS), .WORD_W(WORD_W)) u_data (
        .clk(clk), .idx(req_idx),
        .fill_en(fill_en), .fill_blk(mem_rdata),
        .word_en(word_wr), .word_sel(req_sel), .word_in(req_wdata),
        .blk_o(blk)
    );

    cache_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .req_write(req_write),
        .hit(hit), .victim_dirty(st_valid && st_dirty), .mem_ready(mem_ready),
        .state(state), .latch_req(latch_req), .cpu_ready(cpu_ready),
        .word_wr(word_wr), .mem_valid(mem_valid), .mem_write(mem_write),
        .fill_en(fill_en)
    );

    assign cpu_rdata = blk[req_sel*WORD_W +: WORD_W];
    assign mem_wdata = blk;
    assign mem_addr  = (state == ST_WB) ? {st_tag, req_idx, {OFF_W{1'b0}}}
                                        : {req_tag, req_idx, {OFF_W{1'b0}}};

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_write)
            && $stable(mem_addr) && $stable(mem_wdata))); // R8
    AST_RETRY_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (hit && !mem_valid)); // R5
endmodule

// File: tb/test_dm_wb_cache.sv
`timescale 1ns/1ps
module test_dm_wb_cache;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0, cpu_write = 1'b0;
    logic [31:0]  cpu_addr = '0, cpu_wdata = '0, cpu_rdata;
    logic         cpu_ready, mem_valid, mem_write;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata, mem_rdata = '0;
    logic         mem_ready = 1'b0;

    always #2.5 clk = ~clk;

    dm_wb_cache i_dm_wb_cache (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_write(cpu_write),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .mem_valid(mem_valid), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [127:0] mmem [128];   // memory contents, slot = {tag[2:0], idx[3:0]}
    logic [127:0] gblk [128];   // processor's view of each line
    bit           m_val [16];
    bit           m_dirty [16];
    int           m_tag [16];

    int mwr_cnt = 0, mrd_cnt = 0, op_seq = 0, wr_seq = 0, rd_seq = 0;
    logic [31:0] last_wr_addr = '0, last_rd_addr = '0, hold_addr = '0;
    logic [127:0] hold_wdata = '0;
    bit hold_wr = 0, busy = 0;
    int lat = 0, cnt = 0;

    task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic int slot_of(input int tg, input int ix);
        return ((tg & 7) << 4) | (ix & 15);
    endfunction

    function automatic logic [31:0] line_addr(input int tg, input int ix);
        return {tg[17:0], ix[9:0], 4'b0000};
    endfunction

    // memory model with random latency
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
            busy = 0;
        end else if (mem_valid) begin
            if (!busy) begin
                busy = 1; hold_addr = mem_addr; hold_wr = mem_write; hold_wdata = mem_wdata;
                lat = $urandom_range(0, 3); cnt = 0;
            end else begin
                chk(mem_addr == hold_addr && mem_write == hold_wr && mem_wdata == hold_wdata,
                    "R8 port stable", {mem_write, mem_addr}, {hold_wr, hold_addr});
            end
            if (cnt == lat) begin
                op_seq++;
                if (mem_write) begin
                    chk(mem_wdata == gblk[{mem_addr[16:14], mem_addr[7:4]}], "R6 victim data",
                        mem_wdata, gblk[{mem_addr[16:14], mem_addr[7:4]}]);
                    mmem[{mem_addr[16:14], mem_addr[7:4]}] = mem_wdata;
                    mwr_cnt++; last_wr_addr = mem_addr; wr_seq = op_seq;
                end else begin
                    mem_rdata = mmem[{mem_addr[16:14], mem_addr[7:4]}];
                    mrd_cnt++; last_rd_addr = mem_addr; rd_seq = op_seq;
                end
                mem_ready = 1'b1;
            end else cnt++;
        end
        if (rst_n && cpu_ready && (mem_valid || mem_ready)) begin
            n_chk++; n_fail++;
            $display("FAIL R9: actual ready during memory traffic expected none");
        end
    end

    task automatic access(input bit wr, input int tg, input int ix, input int wd, input logic [31:0] wdat);
        int s, waits, wr0, rd0;
        bit exp_hit, exp_wb;
        logic [31:0] wb_addr;
        s = slot_of(tg, ix);
        exp_hit = m_val[ix] && m_tag[ix] == tg;
        exp_wb  = !exp_hit && m_val[ix] && m_dirty[ix];
        wb_addr = line_addr(m_tag[ix], ix);
        wr0 = mwr_cnt; rd0 = mrd_cnt; waits = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_write = wr;
        cpu_addr = {tg[17:0], ix[9:0], wd[1:0], 2'($urandom_range(0, 3))};
        cpu_wdata = wdat;
        @(negedge clk);
        cpu_req = 1'b0;
        while (!cpu_ready && waits < 100) begin
            @(negedge clk);
            waits++;
        end
        if (!wr)
            chk(cpu_rdata == gblk[s][wd*32 +: 32], exp_hit ? "R3 read hit data" : "R7 read miss data",
                cpu_rdata, gblk[s][wd*32 +: 32]);
        if (exp_hit) begin
            chk(waits == 0, "R3 hit latency", waits, 0);
            chk(mrd_cnt == rd0 && mwr_cnt == wr0, wr ? "R4 no memory on write hit" : "R3 no memory on hit",
                mrd_cnt - rd0 + mwr_cnt - wr0, 0);
        end else begin
            chk(mrd_cnt - rd0 == 1, "R5 one line read", mrd_cnt - rd0, 1);
            chk(last_rd_addr == line_addr(tg, ix), "R2 fetch address", last_rd_addr, line_addr(tg, ix));
            chk(mwr_cnt - wr0 == int'(exp_wb), "R6 write-back count", mwr_cnt - wr0, exp_wb);
            if (exp_wb) begin
                chk(last_wr_addr == wb_addr, "R6 victim address", last_wr_addr, wb_addr);
                chk(wr_seq < rd_seq, "R6 write-back before fetch", wr_seq, rd_seq);
            end
        end
        if (wr) gblk[s][wd*32 +: 32] = wdat;
        m_dirty[ix] = (exp_hit && m_dirty[ix]) || wr;
        m_val[ix] = 1; m_tag[ix] = tg;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1; n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 128; i++) begin
            mmem[i] = {$urandom, $urandom, $urandom, $urandom};
            gblk[i] = mmem[i];
        end
        for (int i = 0; i < 16; i++) begin
            m_val[i] = 0; m_dirty[i] = 0; m_tag[i] = 0;
        end
        repeat (3) @(negedge clk);
        chk(cpu_ready == 0 && mem_valid == 0, "R1 outputs in reset", {cpu_ready, mem_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cpu_ready == 0 && mem_valid == 0, "R1 idle after reset", {cpu_ready, mem_valid}, 0);

        // R1: first access misses; then R3 hit on each word (R2 word select)
        access(0, 1, 0, 2, 0);
        for (int w = 0; w < 4; w++) access(0, 1, 0, w, 0);
        // R4: write hit, then read back
        access(1, 1, 0, 1, 32'hCAFE0001);
        access(0, 1, 0, 1, 0);
        access(0, 1, 0, 0, 0);
        // R6: conflicting tag evicts dirty line; old line returns with written word
        access(0, 2, 0, 3, 0);
        access(0, 1, 0, 1, 0);
        // R7: write miss to an empty index, other words come from memory
        access(1, 3, 5, 2, 32'h12345678);
        access(0, 3, 5, 0, 0);
        access(0, 3, 5, 2, 0);
        // dirty victim plus write allocate in one access (R6 and R7)
        access(1, 4, 5, 3, 32'hDEADBEEF);
        access(0, 4, 5, 3, 0);
        access(0, 3, 5, 2, 0);
        // R2: top test index and alias across tags
        access(1, 7, 15, 0, 32'hA5A5A5A5);
        access(0, 0, 15, 0, 0);
        access(0, 7, 15, 0, 0);

        // constrained random run
        for (int n = 0; n < 1500; n++)
            access($urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 15),
                   $urandom_range(0, 3), $urandom);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule